// File: doc/BRIEF.md
# MMU Control Front End with Safe-Zone Redirect

This block is the control and fault-handling front end of a GPU memory management unit. It holds three control values: a safe-zone base, a master-table configuration (table size mode and table base address) and a translation enable. It also records one exception per translation client. When a client access arrives with a nonzero fault code, the block redirects it into a 64-byte safe zone instead of sending it to the faulting address. Reads still go out. Writes go out with their write enable forced low. Table walking and translation lookup sit elsewhere and feed the fault code in.

Software reaches the block through a word-indexed register port. Writes are strobed. Reads are combinational from `reg_idx`. The register indices are: 0 safe base, 1 configuration, 2 exception status, 3 control, and 4+i the exception address of client i.

Three state machines form the block:

- **Safe-zone lock:** states SAFE_OPEN and SAFE_LOCKED. The transition is `SAFE_OPEN -> SAFE_LOCKED` on the first write to the safe base.
- **Translation enable:** states XLAT_OFF and XLAT_ON. The transition is `XLAT_OFF -> XLAT_ON` on a control write with bit 0 set. No transition leads back.
- **Per-client exception slot:** states SLOT_EMPTY and SLOT_HELD. The transitions are `SLOT_EMPTY -> SLOT_HELD` on a fault from that client, and `SLOT_HELD -> SLOT_EMPTY` on a status write-one-to-clear with no fault from that client in the same cycle.

Top module: `mmu_safe_ctl`

## Requirements
- R1: After reset, every register reads zero, `out_valid`, `flush_pulse` and `xlat_en` are 0, and `tbl_small` is 0 with `tbl_base` zero.
- R2: Only the first write to the safe base (index 0) after reset is kept. Bits 31..6 are stored and bits 5..0 read as zero. Every later write is ignored.
- R3: An access with `acc_code` nonzero appears one cycle later with `out_valid`=1, `out_we`=0 and `out_addr` equal to the safe base bits 31..6 joined with `acc_addr` bits 5..0.
- R4: An access with `acc_code`=0 appears one cycle later with `out_addr`=`acc_addr` and `out_we`=`acc_write`. A cycle without `acc_valid` gives `out_valid`=0 one cycle later.
- R5: A fault from client i stores its code (1 slave absent, 2 page absent, 3 write violation) in status bits 4i+1..4i and stores `acc_vaddr` in the register at index 4+i.
- R6: While a client's code is nonzero, later faults from that client change neither its code nor its exception address.
- R7: A write to the status register (index 2) clears client i when any bit of 4i+3..4i is 1. Other clients are left unchanged.
- R8: A control write (index 3) with bit 0 set turns translation on. `xlat_en` and readback bit 0 then stay 1 through any later write until reset.
- R9: In a configuration write (index 1), mode (bit 0; 0 = 1024-entry table, 1 = 256-entry table) changes only when bit 3 is 1. The table address (bits 31..10) changes only when bit 8 is 1.
- R10: A configuration write with both bit 4 and bit 7 set gives `flush_pulse`=1 for exactly the following cycle. Bit 4 is never stored and reads as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 3 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_idx` |
| acc_valid | input | 1 | Client access present |
| acc_client | input | 2 | Client issuing the access |
| acc_code | input | 2 | Fault code, 0 when no fault |
| acc_vaddr | input | 32 | Faulting address to record |
| acc_addr | input | 32 | Bus address of the access |
| acc_write | input | 1 | Access is a write |
| out_valid | output | 1 | Forwarded access present |
| out_addr | output | 32 | Forwarded or redirected address |
| out_we | output | 1 | Forwarded write enable |
| flush_pulse | output | 1 | One-cycle table cache flush request |
| xlat_en | output | 1 | Translation enabled |
| tbl_small | output | 1 | Master table mode, 1 = 256-entry table |
| tbl_base | output | 32 | Master table base address |

## Verification
The forwarding path is swept over every client, every fault code and both access directions. The low address bits differ on each access. This separates redirect from pass-through, shows whether the offset inside the zone is kept, and shows whether a write enable leaks through on a fault. Exception slots get a distinct code and address per client, then a second fault with different values, to tell first-fault retention from overwrite. Status clears use a single bit inside one client's field, including a bit above the code, to show that only that client is released. The configuration and control registers get writes with mask or enable bits present and absent, so a stored field can be told apart from one that wrongly follows the data.

// File: rtl/mmu_ctl_pkg.sv
`timescale 1ns/1ps
package mmu_ctl_pkg;

    typedef enum logic [1:0] {
        EXC_NONE     = 2'd0,
        EXC_NO_SLAVE = 2'd1,
        EXC_NO_PAGE  = 2'd2,
        EXC_WR_VIOL  = 2'd3
    } exc_code_e;

    typedef enum logic { SAFE_OPEN, SAFE_LOCKED } safe_st_e;
    typedef enum logic { XLAT_OFF, XLAT_ON } xlat_st_e;
    typedef enum logic { SLOT_EMPTY, SLOT_HELD } slot_st_e;

    // register word indices
    localparam int REG_SAFE     = 0;
    localparam int REG_CFG      = 1;
    localparam int REG_STATUS   = 2;
    localparam int REG_CTRL     = 3;
    localparam int REG_EXA_BASE = 4;

    // configuration field positions
    localparam int CFG_MODE_BIT   = 0;
    localparam int CFG_MODE_MASK  = 3;
    localparam int CFG_FLUSH_BIT  = 4;
    localparam int CFG_FLUSH_MASK = 7;
    localparam int CFG_ADDR_MASK  = 8;
    localparam int CFG_ADDR_LO    = 10;

    localparam int CTRL_EN_BIT    = 0;
    localparam int CODE_W         = 2;
    localparam int STATUS_STRIDE  = 4;

endpackage

// File: rtl/mmu_lock_regs.sv
`timescale 1ns/1ps
module mmu_lock_regs
    import mmu_ctl_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ZONE_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_safe,
    input  logic              wr_cfg,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] safe_base,
    output logic              safe_locked,
    output logic [DATA_W-1:0] cfg_word,
    output logic              xlat_en,
    output logic              flush_pulse
);

    safe_st_e safe_st, safe_nx;
    xlat_st_e xl_st, xl_nx;

    logic [DATA_W-1:ZONE_BITS]   zone_q;
    logic                        mode_q;
    logic [DATA_W-1:CFG_ADDR_LO] tbl_q;
    logic                        flush_q;
    logic                        wdata_unused;

    assign wdata_unused = ^wdata;

    // state registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            safe_st <= SAFE_OPEN;
            xl_st   <= XLAT_OFF;
        end else begin
            safe_st <= safe_nx;
            xl_st   <= xl_nx;
        end
    end

    // transitions
    always_comb begin
        safe_nx = safe_st;
        unique case (safe_st)
            SAFE_OPEN:   if (wr_safe) safe_nx = SAFE_LOCKED;
            SAFE_LOCKED: safe_nx = SAFE_LOCKED;
        endcase
        xl_nx = xl_st;
        unique case (xl_st)
            XLAT_OFF: if (wr_ctrl && wdata[CTRL_EN_BIT]) xl_nx = XLAT_ON;
            XLAT_ON:  xl_nx = XLAT_ON;
        endcase
    end

    // held values
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            zone_q  <= '0;
            mode_q  <= 1'b0;
            tbl_q   <= '0;
            flush_q <= 1'b0;
        end else begin
            if (wr_safe && safe_st == SAFE_OPEN)
                zone_q <= wdata[DATA_W-1:ZONE_BITS];
            if (wr_cfg && wdata[CFG_MODE_MASK])
                mode_q <= wdata[CFG_MODE_BIT];
            if (wr_cfg && wdata[CFG_ADDR_MASK])
                tbl_q <= wdata[DATA_W-1:CFG_ADDR_LO];
            flush_q <= wr_cfg && wdata[CFG_FLUSH_BIT] && wdata[CFG_FLUSH_MASK];
        end
    end

    // outputs
    always_comb begin
        safe_base   = {zone_q, {ZONE_BITS{1'b0}}};
        safe_locked = (safe_st == SAFE_LOCKED);
        xlat_en     = (xl_st == XLAT_ON);
        flush_pulse = flush_q;
        cfg_word    = '0;
        cfg_word[CFG_MODE_BIT]            = mode_q;
        cfg_word[DATA_W-1:CFG_ADDR_LO]    = tbl_q;
    end

endmodule

// File: rtl/mmu_exc_slot.sv
`timescale 1ns/1ps
module mmu_exc_slot
    import mmu_ctl_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic              clr,
    input  logic [CODE_W-1:0] code_in,
    input  logic [DATA_W-1:0] vaddr_in,
    output logic [CODE_W-1:0] code_q,
    output logic [DATA_W-1:0] addr_q
);

    slot_st_e st, nx;
    logic     take;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= SLOT_EMPTY;
        else        st <= nx;
    end

    always_comb begin
        nx = st;
        unique case (st)
            SLOT_EMPTY: if (hit) nx = SLOT_HELD;
            SLOT_HELD:  if (clr && !hit) nx = SLOT_EMPTY;
        endcase
    end

    assign take = hit && (st == SLOT_EMPTY || clr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q <= '0;
            addr_q <= '0;
        end else if (take) begin
            code_q <= code_in;
            addr_q <= vaddr_in;
        end else if (clr && st == SLOT_HELD) begin
            code_q <= '0;
        end
    end

endmodule

// File: rtl/mmu_redirect.sv
`timescale 1ns/1ps
module mmu_redirect #(
    parameter int DATA_W    = 32,
    parameter int ZONE_BITS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_fault,
    input  logic              in_write,
    input  logic [DATA_W-1:0] in_addr,
    input  logic [DATA_W-1:0] safe_base,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_addr,
    output logic              out_we
);

    logic base_unused;
    assign base_unused = ^safe_base[ZONE_BITS-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_addr  <= '0;
            out_we    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid && in_fault) begin
                out_addr <= {safe_base[DATA_W-1:ZONE_BITS], in_addr[ZONE_BITS-1:0]};
                out_we   <= 1'b0;
            end else begin
                out_addr <= in_addr;
                out_we   <= in_valid && in_write;
            end
        end
    end

endmodule

// File: rtl/mmu_safe_ctl.sv
`timescale 1ns/1ps
module mmu_safe_ctl
    import mmu_ctl_pkg::*;
#(
    parameter  int DATA_W    = 32,
    parameter  int N_CLIENT  = 4,
    parameter  int ZONE_BITS = 6,
    localparam int CL_W      = (N_CLIENT > 1) ? $clog2(N_CLIENT) : 1,
    localparam int IDX_W     = $clog2(REG_EXA_BASE + N_CLIENT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [IDX_W-1:0]  reg_idx,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              acc_valid,
    input  logic [CL_W-1:0]   acc_client,
    input  logic [CODE_W-1:0] acc_code,
    input  logic [DATA_W-1:0] acc_vaddr,
    input  logic [DATA_W-1:0] acc_addr,
    input  logic              acc_write,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_addr,
    output logic              out_we,
    output logic              flush_pulse,
    output logic              xlat_en,
    output logic              tbl_small,
    output logic [DATA_W-1:0] tbl_base
);

    logic wr_safe, wr_cfg, wr_status, wr_ctrl, fault;
    logic [DATA_W-1:0] safe_base, cfg_word, status_word;
    logic              safe_locked;
    logic [CODE_W-1:0] slot_code [N_CLIENT];
    logic [DATA_W-1:0] slot_addr [N_CLIENT];

    assign wr_safe   = reg_wr && (reg_idx == IDX_W'(REG_SAFE));
    assign wr_cfg    = reg_wr && (reg_idx == IDX_W'(REG_CFG));
    assign wr_status = reg_wr && (reg_idx == IDX_W'(REG_STATUS));
    assign wr_ctrl   = reg_wr && (reg_idx == IDX_W'(REG_CTRL));
    assign fault     = acc_valid && (acc_code != EXC_NONE);

    mmu_lock_regs #(.DATA_W(DATA_W), .ZONE_BITS(ZONE_BITS)) u_lock (
        .clk(clk), .rst_n(rst_n),
        .wr_safe(wr_safe), .wr_cfg(wr_cfg), .wr_ctrl(wr_ctrl),
        .wdata(reg_wdata),
        .safe_base(safe_base), .safe_locked(safe_locked),
        .cfg_word(cfg_word), .xlat_en(xlat_en), .flush_pulse(flush_pulse)
    );

    for (genvar g = 0; g < N_CLIENT; g++) begin : g_slot
        logic hit_g, clr_g;
        assign hit_g = fault && (acc_client == CL_W'(g));
        assign clr_g = wr_status && (|reg_wdata[STATUS_STRIDE*g +: STATUS_STRIDE]);
        mmu_exc_slot #(.DATA_W(DATA_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .hit(hit_g), .clr(clr_g),
            .code_in(acc_code), .vaddr_in(acc_vaddr),
            .code_q(slot_code[g]), .addr_q(slot_addr[g])
        );
    end

    mmu_redirect #(.DATA_W(DATA_W), .ZONE_BITS(ZONE_BITS)) u_redir (
        .clk(clk), .rst_n(rst_n),
        .in_valid(acc_valid), .in_fault(fault), .in_write(acc_write),
        .in_addr(acc_addr), .safe_base(safe_base),
        .out_valid(out_valid), .out_addr(out_addr), .out_we(out_we)
    );

    always_comb begin
        status_word = '0;
        for (int i = 0; i < N_CLIENT; i++)
            status_word[STATUS_STRIDE*i +: CODE_W] = slot_code[i];
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_idx == IDX_W'(REG_SAFE))        reg_rdata = safe_base;
        else if (reg_idx == IDX_W'(REG_CFG))    reg_rdata = cfg_word;
        else if (reg_idx == IDX_W'(REG_STATUS)) reg_rdata = status_word;
        else if (reg_idx == IDX_W'(REG_CTRL))   reg_rdata = {{(DATA_W-1){1'b0}}, xlat_en};
        else begin
            for (int i = 0; i < N_CLIENT; i++)
                if (reg_idx == IDX_W'(REG_EXA_BASE + i)) reg_rdata = slot_addr[i];
        end
    end

    assign tbl_small = cfg_word[CFG_MODE_BIT];
    assign tbl_base  = {cfg_word[DATA_W-1:CFG_ADDR_LO], {CFG_ADDR_LO{1'b0}}};

endmodule

// File: rtl/mmu_safe_ctl_chk.sv
`timescale 1ns/1ps
module mmu_safe_ctl_chk
    import mmu_ctl_pkg::*;
#(
    parameter  int DATA_W    = 32,
    parameter  int N_CLIENT  = 4,
    parameter  int ZONE_BITS = 6,
    localparam int IDX_W     = $clog2(REG_EXA_BASE + N_CLIENT)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr,
    input logic [IDX_W-1:0]  reg_idx,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              acc_valid,
    input logic [CODE_W-1:0] acc_code,
    input logic [DATA_W-1:0] acc_addr,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_addr,
    input logic              out_we,
    input logic              flush_pulse,
    input logic              xlat_en,
    input logic [DATA_W-1:0] safe_base,
    input logic              safe_locked,
    input logic [DATA_W-1:0] status_word
);

    logic wdata_unused;
    assign wdata_unused = ^reg_wdata;

    // R2
    safe_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        safe_locked |=> $stable(safe_base));

    // R8
    xlat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xlat_en |=> xlat_en);

    // R3
    redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_code != 2'd0) |=>
            (out_valid && !out_we
             && out_addr[ZONE_BITS-1:0] == $past(acc_addr[ZONE_BITS-1:0])
             && out_addr[DATA_W-1:ZONE_BITS] == $past(safe_base[DATA_W-1:ZONE_BITS])));

    // R4
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_code == 2'd0) |=> (out_valid && out_addr == $past(acc_addr)));

    // R10
    flush_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush_pulse |-> $past(reg_wr && reg_idx == IDX_W'(REG_CFG)
                              && reg_wdata[CFG_FLUSH_BIT] && reg_wdata[CFG_FLUSH_MASK]));

    for (genvar g = 0; g < N_CLIENT; g++) begin : g_held
        // R6
        held_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (status_word[STATUS_STRIDE*g +: CODE_W] != 2'd0
             && !(reg_wr && reg_idx == IDX_W'(REG_STATUS)))
            |=> $stable(status_word[STATUS_STRIDE*g +: CODE_W]));
    end

endmodule

bind mmu_safe_ctl mmu_safe_ctl_chk #(
    .DATA_W(DATA_W), .N_CLIENT(N_CLIENT), .ZONE_BITS(ZONE_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
    .reg_wdata(reg_wdata), .acc_valid(acc_valid), .acc_code(acc_code),
    .acc_addr(acc_addr), .out_valid(out_valid), .out_addr(out_addr),
    .out_we(out_we), .flush_pulse(flush_pulse), .xlat_en(xlat_en),
    .safe_base(safe_base), .safe_locked(safe_locked), .status_word(status_word)
);

// File: tb/sim_mmu_safe_ctl.sv
`timescale 1ns/1ps
module sim_mmu_safe_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_idx = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        acc_valid = 1'b0;
    logic [1:0]  acc_client = '0;
    logic [1:0]  acc_code = '0;
    logic [31:0] acc_vaddr = '0;
    logic [31:0] acc_addr = '0;
    logic        acc_write = 1'b0;
    logic        out_valid, out_we, flush_pulse, xlat_en, tbl_small;
    logic [31:0] out_addr, tbl_base;

    int nchk = 0;
    int nfail = 0;
    bit done = 0;
    logic [1:0]  m_code [4];
    logic [31:0] m_addr [4];
    logic [31:0] safe_exp;

    always #10 clk = ~clk;

    mmu_safe_ctl u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_idx(reg_idx),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .acc_valid(acc_valid), .acc_client(acc_client), .acc_code(acc_code),
        .acc_vaddr(acc_vaddr), .acc_addr(acc_addr), .acc_write(acc_write),
        .out_valid(out_valid), .out_addr(out_addr), .out_we(out_we),
        .flush_pulse(flush_pulse), .xlat_en(xlat_en),
        .tbl_small(tbl_small), .tbl_base(tbl_base)
    );

    task automatic tick;
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int idx, input logic [31:0] d);
        reg_wr = 1'b1; reg_idx = 3'(idx); reg_wdata = d;
        tick;
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic rd(input int idx, input string tag, input logic [31:0] exp);
        reg_idx = 3'(idx);
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic access(input int cl, input int code, input logic [31:0] va,
                          input logic [31:0] a, input logic w);
        acc_valid = 1'b1; acc_client = 2'(cl); acc_code = 2'(code);
        acc_vaddr = va; acc_addr = a; acc_write = w;
        tick;
        acc_valid = 1'b0; acc_code = '0;
        if (code != 0 && m_code[cl] == 2'd0) begin
            m_code[cl] = 2'(code);
            m_addr[cl] = va;
        end
    endtask

    function automatic logic [31:0] status_exp();
        logic [31:0] s = '0;
        for (int i = 0; i < 4; i++) s[4*i +: 2] = m_code[i];
        return s;
    endfunction

    task automatic check_slots(input string tag);
        rd(2, {tag, " status"}, status_exp());
        for (int i = 0; i < 4; i++) rd(4 + i, {tag, " exaddr"}, m_addr[i]);
    endtask

    initial begin
        for (int i = 0; i < 4; i++) begin m_code[i] = '0; m_addr[i] = '0; end
        repeat (3) tick;
        rst_n = 1'b1;
        tick;

        // R1 reset state
        for (int i = 0; i < 8; i++) rd(i, "R1 reg reset", 32'h0);
        chk("R1 out_valid", {31'b0, out_valid}, 32'h0);
        chk("R1 flush", {31'b0, flush_pulse}, 32'h0);
        chk("R1 xlat_en", {31'b0, xlat_en}, 32'h0);
        chk("R1 tbl_small", {31'b0, tbl_small}, 32'h0);
        chk("R1 tbl_base", tbl_base, 32'h0);

        // R2 write-once safe base
        wr(0, 32'h1234_56BF);
        safe_exp = 32'h1234_5680;
        rd(0, "R2 first write", safe_exp);
        wr(0, 32'hFFFF_FFFF);
        rd(0, "R2 second write ignored", safe_exp);
        wr(0, 32'h0000_0040);
        rd(0, "R2 third write ignored", safe_exp);

        // R3 / R4 sweep over clients, codes and direction
        for (int cl = 0; cl < 4; cl++)
            for (int code = 0; code < 4; code++)
                for (int w = 0; w < 2; w++) begin
                    logic [31:0] a;
                    a = 32'hA000_0000 + 32'(cl) * 32'h0001_1111 + 32'(code) * 32'd7 + 32'(w) * 32'h25;
                    access(cl, code, 32'hB000_0000 + 32'(cl * 16 + code), a, w[0]);
                    chk("R3R4 out_valid", {31'b0, out_valid}, 32'h1);
                    if (code != 0) begin
                        chk("R3 redirected addr", out_addr, {safe_exp[31:6], a[5:0]});
                        chk("R3 write enable low", {31'b0, out_we}, 32'h0);
                    end else begin
                        chk("R4 passthru addr", out_addr, a);
                        chk("R4 passthru we", {31'b0, out_we}, 32'(w));
                    end
                end
        tick;
        chk("R4 idle out_valid", {31'b0, out_valid}, 32'h0);
        check_slots("R6 after sweep");

        // clear everything, then R5 distinct recording per client
        wr(2, 32'h0000_FFFF);
        for (int i = 0; i < 4; i++) m_code[i] = '0;
        rd(2, "R7 clear all", 32'h0);
        for (int i = 0; i < 4; i++)
            access(i, (i % 3) + 1, 32'hC0DE_0000 + 32'(i) * 32'h100, 32'h10 + 32'(i), 1'b1);
        check_slots("R5 record");
        chk("R5 status value", status_exp(), 32'h0000_1321);

        // R6 second faults do not overwrite
        for (int i = 0; i < 4; i++)
            access(i, 3 - (i % 3), 32'hDEAD_0000 + 32'(i), 32'h0, 1'b0);
        check_slots("R6 kept");

        // R7 single-bit clears
        wr(2, 32'h0000_0010);            // client 1 via bit 4
        m_code[1] = '0;
        rd(2, "R7 clear client1", status_exp());
        wr(2, 32'h0000_0008);            // client 0 via bit 3 (above the code)
        m_code[0] = '0;
        rd(2, "R7 clear client0 upper bit", status_exp());
        access(1, 3, 32'h5555_AAAA, 32'h0, 1'b0);
        check_slots("R7 refill client1");

        // R8 sticky enable
        rd(3, "R8 ctrl off", 32'h0);
        wr(3, 32'h0000_0002);
        rd(3, "R8 bit0 clear no effect", 32'h0);
        wr(3, 32'h0000_0001);
        rd(3, "R8 ctrl on", 32'h1);
        chk("R8 xlat_en on", {31'b0, xlat_en}, 32'h1);
        wr(3, 32'h0000_0000);
        rd(3, "R8 stays on", 32'h1);
        chk("R8 xlat_en stays", {31'b0, xlat_en}, 32'h1);

        // R9 masked configuration fields
        wr(1, 32'h0000_0001);
        rd(1, "R9 mode without mask", 32'h0);
        wr(1, 32'h0000_0009);
        rd(1, "R9 mode with mask", 32'h1);
        chk("R9 tbl_small", {31'b0, tbl_small}, 32'h1);
        wr(1, 32'hFFFF_FC00);
        rd(1, "R9 addr without mask", 32'h1);
        wr(1, 32'hABCD_E500);
        rd(1, "R9 addr with mask", 32'hABCD_E401);
        chk("R9 tbl_base", tbl_base, 32'hABCD_E400);
        wr(1, 32'h0000_0108);
        rd(1, "R9 both fields cleared", 32'h0);

        // R10 flush pulse
        wr(1, 32'h0000_0010);
        chk("R10 flush needs mask", {31'b0, flush_pulse}, 32'h0);
        wr(1, 32'h0000_0090);
        chk("R10 flush pulse", {31'b0, flush_pulse}, 32'h1);
        rd(1, "R10 flush not stored", 32'h0);
        tick;
        chk("R10 flush single cycle", {31'b0, flush_pulse}, 32'h0);

        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog (all requirements) actual=hung expected=finished");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

endmodule